// File: doc/BRIEF.md
# Converter Output Sequencer with Sync-Loss Recovery

This block decides, cycle by cycle, what a stereo converter's serial data path may send: real samples, forced zeros, or nothing meaningful. It runs on the system clock. A power-good input is stretched into an internal reset of a fixed number of system-clock cycles. After that reset ends, the output is kept at zero for a settling time counted in sample periods, and only then are normal samples allowed through.

While the converter runs, the block measures each sample period (the time between rising edges of the word clock) in system-clock cycles. It also counts the bit clocks in that period. The nominal period is learned from a family of three system-clock ratios. The deviation of each period is expressed in bit-clock units. A deviation above an upper limit halts the converter and marks the output as undefined. The block then waits for two clean periods in a row, inserts a short run of zero frames, and returns to normal data. A deviation between the lower and upper limits changes nothing, which gives the detector hysteresis.

Top module: `adc_out_sequencer`

## Requirements
- R1: While `pwr_ok` is low, `int_rst_o` is 1, `out_mode_o` is 2'b01 (zero data), `halt_o` is 0 and `state_o` is 3'd0 (reset).
- R2: After `pwr_ok` rises, `int_rst_o` stays high for exactly RST_CYC system-clock cycles. It then falls, and `state_o` becomes 3'd1 (settling).
- R3: In settling, `out_mode_o` stays 2'b01 until SETTLE_FRAMES rising word-clock edges have been seen. On the last of these edges, `state_o` becomes 3'd2 (running) and `out_mode_o` becomes 2'b00 (normal data).
- R4: The nominal period is learned from a measured period. It is BASE_RATIO, 1.5×BASE_RATIO or 2×BASE_RATIO cycles, whichever is nearest, with the decision points at the midpoints. The bit clocks per period are learned at the same time. Learning happens in reset, in loss, and until the first value is held; otherwise both values are frozen. Drift in bit clocks is |period − nominal| × bits / nominal.
- R5: In settling, running or recovery, a word-clock edge whose drift is above DRIFT_HI bit clocks moves the block to loss from the next cycle. Loss means `state_o` 3'd3, `out_mode_o` 2'b10 (undefined) and `halt_o` 1.
- R6: If no word-clock edge has arrived and the elapsed time already exceeds the nominal period by more than DRIFT_HI bit clocks, loss is entered before that edge arrives.
- R7: A period whose drift is below DRIFT_LO bit clocks leaves the state and the output mode unchanged while running.
- R8: A drift from DRIFT_LO to DRIFT_HI inclusive keeps the current state. While running, this means no loss. While in loss, it breaks the run of clean periods.
- R9: In loss, two consecutive periods with drift below DRIFT_LO move the block to recovery: `state_o` 3'd4, `out_mode_o` 2'b01 and `halt_o` 0.
- R10: Recovery lasts RESYNC_FRAMES rising word-clock edges. The block then returns to running with `out_mode_o` 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock; every register runs on its rising edge |
| pwr_ok | input | 1 | Power-good indication; low holds everything in reset (asynchronous) |
| bit_clk | input | 1 | Serial bit clock, sampled on the system clock |
| word_clk | input | 1 | Word (sample) clock, sampled on the system clock |
| int_rst_o | output | 1 | Internal reset for the filter and data logic |
| halt_o | output | 1 | High while synchronization is lost |
| out_mode_o | output | 2 | 00 normal, 01 zero, 10 undefined |
| state_o | output | 3 | 0 reset, 1 settling, 2 running, 3 loss, 4 recovery |

## Verification
The hardest case to reach from the ports is a loss declared before the offending word-clock edge arrives. A close second is a loss whose clean-period run is broken by a drift inside the hysteresis band. The bench drives the clocks from a frame generator whose length can be stretched or shortened for exactly one frame. This lets it place a deviation of a chosen number of bit clocks on either side of each limit. For the late case, it samples in the last few cycles of a stretched frame, before the closing edge. Re-powering with 384- and 512-cycle frames shows that the limits scale with the learned ratio and the learned bit count.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_RESET   = 3'd0,
        ST_SETTLE  = 3'd1,
        ST_RUN     = 3'd2,
        ST_LOST    = 3'd3,
        ST_RECOVER = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        OUT_NORMAL = 2'b00,
        OUT_ZERO   = 2'b01,
        OUT_UNDEF  = 2'b10
    } out_mode_e;

    function automatic int unsigned max_of3(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/seq_edge_sync.sv
module seq_edge_sync #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sig_i,
    output logic [WIDTH-1:0] rise_o
);

    typedef struct packed {
        logic [WIDTH-1:0] smp;
        logic [WIDTH-1:0] prv;
    } edge_regs_t;

    edge_regs_t edge_d, edge_q;

    always_comb begin
        edge_d     = edge_q;
        edge_d.smp = sig_i;
        edge_d.prv = edge_q.smp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_q <= '0;
        else        edge_q <= edge_d;
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_rise
        assign rise_o[g] = edge_q.smp[g] & ~edge_q.prv[g];
    end

endmodule

// File: rtl/seq_frame_meter.sv
module seq_frame_meter #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_rise_i,
    input  logic             bit_rise_i,
    output logic [CNT_W-1:0] elapsed_o,
    output logic [CNT_W-1:0] bits_o,
    output logic             valid_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] bcnt;
        logic             seen;
    } meter_regs_t;

    meter_regs_t mtr_d, mtr_q;
    logic [CNT_W-1:0] elapsed_w;
    logic [CNT_W-1:0] bits_w;

    // Both counters saturate so a stopped clock never wraps back into range.
    always_comb begin
        elapsed_w = (mtr_q.cnt == CNT_MAX) ? CNT_MAX : mtr_q.cnt + CNT_W'(1);
        bits_w    = (bit_rise_i && (mtr_q.bcnt != CNT_MAX)) ?
                    mtr_q.bcnt + CNT_W'(1) : mtr_q.bcnt;
        mtr_d = mtr_q;
        if (frame_rise_i) begin
            mtr_d.cnt  = '0;
            mtr_d.bcnt = '0;
            mtr_d.seen = 1'b1;
        end else begin
            mtr_d.cnt  = elapsed_w;
            mtr_d.bcnt = bits_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mtr_q <= '0;
        else        mtr_q <= mtr_d;
    end

    assign elapsed_o = elapsed_w;
    assign bits_o    = bits_w;
    assign valid_o   = mtr_q.seen;

    // R6: late detection depends on the elapsed count never wrapping
    p_count_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_rise_i && mtr_q.cnt == CNT_MAX) |=> (mtr_q.cnt == CNT_MAX));

endmodule

// File: rtl/seq_drift_judge.sv
module seq_drift_judge #(
    parameter int unsigned CNT_W      = 10,
    parameter int unsigned BASE_RATIO = 256,
    parameter int unsigned DRIFT_HI   = 6,
    parameter int unsigned DRIFT_LO   = 5
) (
    input  logic [CNT_W-1:0] elapsed_i,
    input  logic [CNT_W-1:0] nom_i,
    input  logic [CNT_W-1:0] bits_i,
    output logic [CNT_W-1:0] snap_o,
    output logic             late_o,
    output logic             bad_o,
    output logic             good_o
);

    localparam int unsigned RATIO_A = BASE_RATIO;
    localparam int unsigned RATIO_B = (BASE_RATIO * 3) / 2;
    localparam int unsigned RATIO_C = BASE_RATIO * 2;
    localparam int unsigned SPLIT_AB = (RATIO_A + RATIO_B) / 2;
    localparam int unsigned SPLIT_BC = (RATIO_B + RATIO_C) / 2;
    localparam int unsigned PROD_W   = 2 * CNT_W + 4;

    logic [CNT_W-1:0]  dev_w;
    logic [PROD_W-1:0] scaled_w;
    logic [PROD_W-1:0] hi_lim_w;
    logic [PROD_W-1:0] lo_lim_w;

    always_comb begin
        if (elapsed_i < CNT_W'(SPLIT_AB))      snap_o = CNT_W'(RATIO_A);
        else if (elapsed_i < CNT_W'(SPLIT_BC)) snap_o = CNT_W'(RATIO_B);
        else                                   snap_o = CNT_W'(RATIO_C);

        dev_w    = (elapsed_i >= nom_i) ? elapsed_i - nom_i : nom_i - elapsed_i;
        // drift in bit clocks = dev * bits / nom; compared without dividing
        scaled_w = PROD_W'(dev_w) * PROD_W'(bits_i);
        hi_lim_w = PROD_W'(DRIFT_HI) * PROD_W'(nom_i);
        lo_lim_w = PROD_W'(DRIFT_LO) * PROD_W'(nom_i);

        late_o = elapsed_i > nom_i;
        bad_o  = scaled_w > hi_lim_w;
        good_o = scaled_w < lo_lim_w;
    end

endmodule

// File: rtl/adc_out_sequencer.sv
module adc_out_sequencer
    import adc_seq_pkg::*;
#(
    parameter int unsigned RST_CYC       = 1024,
    parameter int unsigned SETTLE_FRAMES = 18436,
    parameter int unsigned RESYNC_FRAMES = 32,
    parameter int unsigned BASE_RATIO    = 256,
    parameter int unsigned DRIFT_HI      = 6,
    parameter int unsigned DRIFT_LO      = 5
) (
    input  logic       clk_sys,
    input  logic       pwr_ok,
    input  logic       bit_clk,
    input  logic       word_clk,
    output logic       int_rst_o,
    output logic       halt_o,
    output logic [1:0] out_mode_o,
    output logic [2:0] state_o
);

    localparam int unsigned CNT_W = $clog2(BASE_RATIO * 4);
    localparam int unsigned TMR_W =
        $clog2(max_of3(RST_CYC, SETTLE_FRAMES, RESYNC_FRAMES) + 1);
    localparam logic [TMR_W-1:0] RST_LAST    = TMR_W'(RST_CYC - 1);
    localparam logic [TMR_W-1:0] SETTLE_LAST = TMR_W'(SETTLE_FRAMES - 1);
    localparam logic [TMR_W-1:0] RESYNC_LAST = TMR_W'(RESYNC_FRAMES - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [TMR_W-1:0] tmr;
        logic [CNT_W-1:0] nom;
        logic [CNT_W-1:0] nbits;
        logic             have_nom;
        logic             streak;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic [1:0]       rise_w;
    logic             frame_rise_w;
    logic             bit_rise_w;
    logic [CNT_W-1:0] elapsed_w;
    logic [CNT_W-1:0] bits_w;
    logic             valid_w;
    logic [CNT_W-1:0] snap_w;
    logic             late_w;
    logic             bad_w;
    logic             good_w;
    logic             learn_w;
    logic             hit_w;

    seq_edge_sync #(.WIDTH(2)) i_edge (
        .clk    (clk_sys),
        .rst_n  (pwr_ok),
        .sig_i  ({word_clk, bit_clk}),
        .rise_o (rise_w)
    );

    assign frame_rise_w = rise_w[1];
    assign bit_rise_w   = rise_w[0];

    seq_frame_meter #(.CNT_W(CNT_W)) i_meter (
        .clk          (clk_sys),
        .rst_n        (pwr_ok),
        .frame_rise_i (frame_rise_w),
        .bit_rise_i   (bit_rise_w),
        .elapsed_o    (elapsed_w),
        .bits_o       (bits_w),
        .valid_o      (valid_w)
    );

    seq_drift_judge #(
        .CNT_W      (CNT_W),
        .BASE_RATIO (BASE_RATIO),
        .DRIFT_HI   (DRIFT_HI),
        .DRIFT_LO   (DRIFT_LO)
    ) i_judge (
        .elapsed_i (elapsed_w),
        .nom_i     (seq_q.nom),
        .bits_i    (seq_q.nbits),
        .snap_o    (snap_w),
        .late_o    (late_w),
        .bad_o     (bad_w),
        .good_o    (good_w)
    );

    assign learn_w = (seq_q.state == ST_RESET) || (seq_q.state == ST_LOST) ||
                     !seq_q.have_nom;
    assign hit_w   = seq_q.have_nom && bad_w && (frame_rise_w || late_w);

    always_comb begin
        seq_d = seq_q;
        if (frame_rise_w && valid_w && learn_w) begin
            seq_d.nom      = snap_w;
            seq_d.nbits    = bits_w;
            seq_d.have_nom = 1'b1;
        end
        unique case (seq_q.state)
            ST_RESET: begin
                seq_d.tmr = seq_q.tmr + TMR_W'(1);
                if (seq_q.tmr == RST_LAST) begin
                    seq_d.state = ST_SETTLE;
                    seq_d.tmr   = '0;
                end
            end
            ST_SETTLE, ST_RECOVER: begin
                if (hit_w) begin
                    seq_d.state  = ST_LOST;
                    seq_d.streak = 1'b0;
                end else if (frame_rise_w) begin
                    seq_d.tmr = seq_q.tmr + TMR_W'(1);
                    if (seq_q.tmr == ((seq_q.state == ST_SETTLE) ? SETTLE_LAST
                                                                 : RESYNC_LAST)) begin
                        seq_d.state = ST_RUN;
                        seq_d.tmr   = '0;
                    end
                end
            end
            ST_RUN: begin
                if (hit_w) begin
                    seq_d.state  = ST_LOST;
                    seq_d.streak = 1'b0;
                end
            end
            ST_LOST: begin
                if (frame_rise_w && valid_w) begin
                    if (good_w && seq_q.have_nom) begin
                        if (seq_q.streak) begin
                            seq_d.state  = ST_RECOVER;
                            seq_d.tmr    = '0;
                            seq_d.streak = 1'b0;
                        end else begin
                            seq_d.streak = 1'b1;
                        end
                    end else begin
                        seq_d.streak = 1'b0;
                    end
                end
            end
            default: begin
                seq_d.state = ST_RESET;
                seq_d.tmr   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_sys or negedge pwr_ok) begin
        if (!pwr_ok) seq_q <= '0;
        else         seq_q <= seq_d;
    end

    always_comb begin
        unique case (seq_q.state)
            ST_RUN:  out_mode_o = OUT_NORMAL;
            ST_LOST: out_mode_o = OUT_UNDEF;
            default: out_mode_o = OUT_ZERO;
        endcase
    end

    assign int_rst_o = (seq_q.state == ST_RESET);
    assign halt_o    = (seq_q.state == ST_LOST);
    assign state_o   = seq_q.state;

    p_reset_len_r2: assert property (@(posedge clk_sys) disable iff (!pwr_ok)
        $fell(int_rst_o) |-> ($past(seq_q.tmr) == RST_LAST));

    p_lost_early_r5: assert property (@(posedge clk_sys) disable iff (!pwr_ok)
        ((seq_q.state inside {ST_SETTLE, ST_RUN, ST_RECOVER}) && seq_q.have_nom &&
         frame_rise_w && bad_w) |=> (seq_q.state == ST_LOST));

    p_lost_late_r6: assert property (@(posedge clk_sys) disable iff (!pwr_ok)
        ((seq_q.state == ST_RUN) && seq_q.have_nom && late_w && bad_w)
        |=> (seq_q.state == ST_LOST));

    p_hold_band_r8: assert property (@(posedge clk_sys) disable iff (!pwr_ok)
        ((seq_q.state == ST_RUN) && seq_q.have_nom && frame_rise_w && !bad_w)
        |=> (seq_q.state == ST_RUN));

    p_resync_streak_r9: assert property (@(posedge clk_sys) disable iff (!pwr_ok)
        ((seq_q.state == ST_RECOVER) && ($past(seq_q.state) == ST_LOST))
        |-> ($past(seq_q.streak) && $past(good_w) && $past(frame_rise_w)));

    p_run_entry_r10: assert property (@(posedge clk_sys) disable iff (!pwr_ok)
        $rose(seq_q.state == ST_RUN)
        |-> ($past(seq_q.state) inside {ST_SETTLE, ST_RECOVER}));

endmodule

// File: tb/test_adc_out_sequencer.sv
module test_adc_out_sequencer;

    localparam int T_RST = 20;
    localparam int T_SET = 6;
    localparam int T_RES = 4;

    typedef struct packed {
        int         drift;
        logic [1:0] mode;
        logic       halt;
        logic [2:0] st;
        int         req;
    } vec_t;

    // drift (system clocks) applied to one frame; bit clock = 8 system clocks
    localparam vec_t VECS [11] = '{
        '{ 32, 2'b00, 1'b0, 3'd2, 7 },  // R7: 4 bit clocks late
        '{-32, 2'b00, 1'b0, 3'd2, 7 },  // R7: 4 bit clocks early
        '{ 40, 2'b00, 1'b0, 3'd2, 8 },  // R8: exactly 5
        '{-40, 2'b00, 1'b0, 3'd2, 8 },  // R8
        '{ 48, 2'b00, 1'b0, 3'd2, 8 },  // R8: exactly 6
        '{-48, 2'b00, 1'b0, 3'd2, 8 },  // R8
        '{-56, 2'b10, 1'b1, 3'd3, 5 },  // R5: 7 early -> loss
        '{ 40, 2'b10, 1'b1, 3'd3, 8 },  // R8: band frame breaks clean run
        '{  0, 2'b01, 1'b0, 3'd4, 9 },  // R9: two clean frames
        '{  0, 2'b01, 1'b0, 3'd4, 10},  // R10: recovery counting
        '{  0, 2'b00, 1'b0, 3'd2, 10}   // R10: back to normal
    };

    logic       clk = 1'b0;
    logic       pwr_ok = 1'b0;
    logic       bclk = 1'b0;
    logic       wclk = 1'b0;
    logic       int_rst;
    logic       halt;
    logic [1:0] mode;
    logic [2:0] st;

    int k = 0, cur_len = 256, nom_len = 256, extra = 0, bsh = 2, n_rises = 0;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    adc_out_sequencer #(
        .RST_CYC       (T_RST),
        .SETTLE_FRAMES (T_SET),
        .RESYNC_FRAMES (T_RES),
        .BASE_RATIO    (256),
        .DRIFT_HI      (6),
        .DRIFT_LO      (5)
    ) i_adc_out_sequencer (
        .clk_sys    (clk),
        .pwr_ok     (pwr_ok),
        .bit_clk    (bclk),
        .word_clk   (wclk),
        .int_rst_o  (int_rst),
        .halt_o     (halt),
        .out_mode_o (mode),
        .state_o    (st)
    );

    initial begin
        forever begin
            @(negedge clk);
            if (k >= cur_len - 1) begin
                k = 0;
                cur_len = nom_len + extra;
                extra = 0;
                n_rises++;
            end else begin
                k++;
            end
            wclk = (k < cur_len / 2);
            bclk = k[bsh];
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic wait_rises(input int n);
        int tgt;
        tgt = n_rises + n;
        wait (n_rises >= tgt);
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R10 progress actual=%0d expected=%0d", 0, 1);
        finish_up();
    end

    initial begin
        // R1: held in reset
        repeat (5) @(posedge clk);
        #1;
        chk("R1 int_rst", int_rst, 1);
        chk("R1 mode zero", mode, 1);
        chk("R1 halt", halt, 0);
        chk("R1 state", st, 0);

        // R2: reset length
        @(negedge clk) pwr_ok = 1'b1;
        repeat (T_RST - 1) @(posedge clk);
        #1;
        chk("R2 reset still held", int_rst, 1);
        @(posedge clk);
        #1;
        chk("R2 reset released", int_rst, 0);
        chk("R2 settle state", st, 1);

        // R3: settling interval
        chk("R3 zero at settle start", mode, 1);
        wait_rises(T_SET - 1);
        chk("R3 zero before last frame", mode, 1);
        wait_rises(1);
        chk("R3 normal after settle", mode, 0);
        chk("R3 running state", st, 2);

        // table of single-frame drifts: R5 R7 R8 R9 R10
        for (int i = 0; i < 11; i++) begin
            extra = VECS[i].drift;
            wait_rises(2);
            chk($sformatf("R%0d vec%0d mode", VECS[i].req, i), mode, VECS[i].mode);
            chk($sformatf("R%0d vec%0d halt", VECS[i].req, i), halt, VECS[i].halt);
            chk($sformatf("R%0d vec%0d state", VECS[i].req, i), st, VECS[i].st);
        end

        // R6: 7 bit clocks late, loss before the closing edge
        extra = 56;
        wait_rises(1);
        wait (k >= 308);
        @(posedge clk);
        #1;
        chk("R6 halt before edge", halt, 1);
        chk("R6 undefined before edge", mode, 2);
        chk("R6 no edge yet", (k < 312) ? 1 : 0, 1);
        wait_rises(3);
        chk("R9 recovery after late loss", st, 4);
        chk("R9 zero in recovery", mode, 1);
        wait_rises(T_RES);
        chk("R10 running again", st, 2);

        // R4: 384-cycle frames, 48 bit clocks each
        @(negedge clk) pwr_ok = 1'b0;
        nom_len = 384;
        wait_rises(2);
        chk("R1 reset re-entered", st, 0);
        @(negedge clk) pwr_ok = 1'b1;
        wait_rises(T_SET);
        chk("R4 ratio 384 reaches run", st, 2);
        extra = 48;
        wait_rises(2);
        chk("R4 ratio 384 six bit clocks kept", st, 2);
        extra = -56;
        wait_rises(2);
        chk("R4 ratio 384 seven bit clocks lost", st, 3);

        // R4: 512-cycle frames, bit clock of 16 system clocks
        @(negedge clk) pwr_ok = 1'b0;
        nom_len = 512;
        bsh = 3;
        wait_rises(2);
        @(negedge clk) pwr_ok = 1'b1;
        wait_rises(T_SET);
        chk("R4 ratio 512 reaches run", st, 2);
        extra = 96;
        wait_rises(2);
        chk("R4 ratio 512 six bit clocks kept", st, 2);
        extra = -104;
        wait_rises(2);
        chk("R4 ratio 512 beyond limit lost", st, 3);
        chk("R5 halt at ratio 512", halt, 1);

        finish_up();
    end

endmodule